// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block watches a clock/calendar that lives elsewhere and raises alarms when the current time agrees with one of two programmed alarm register sets. Each set holds four bytes: seconds, minutes, hours and day of week. Bit 7 of every alarm byte is a mask. A masked field takes no part in the comparison, so one set can fire every second, every minute, every hour, every day or once a week.

Comparison happens only on the cycle of the once-per-second update strobe. On a match, a sticky request flag is set for that alarm. A flag stays set until the bus side moves its address pointer onto any register of the same alarm set, either for a read or for a write. Alarm 0 drives an active-low level interrupt that stays low while its flag and its enable bit are both set. Alarm 1 drives an active-high pulse of fixed length. The enable bits come from a control byte.

Top module: `tod_alarm`

## Requirements
- R1: While reset is high, and on the first cycle after it, both flags read 0, the level interrupt reads 1 and the pulse output reads 0.
- R2: Byte k of a 32-bit time or alarm word is field k: sec=0, min=1, hour=2, day=3. Bits 6:0 of each unmasked alarm byte are compared with bits 6:0 of the matching time byte. When all unmasked fields are equal on a strobe cycle, the alarm's flag (flags bit 0 for alarm 0, bit 1 for alarm 1) reads 1 from the next cycle on.
- R3: An alarm byte with bit 7 set takes no part in the comparison. With all four bytes masked, every strobe is a match. With only seconds and minutes unmasked, the hour and day values have no effect.
- R4: With the strobe low, a flag is never set, even when the fields agree.
- R5: A pointer visit to address 07h–0Ah, or the same address with bit 7 set (87h–8Ah), clears flag 0 on the next cycle. A visit to 0Bh–0Eh or 8Bh–8Eh clears flag 1. A visit to any other address leaves both flags unchanged.
- R6: If a set and a clear of the same flag fall in the same cycle, the set wins and the flag reads 1.
- R7: The level interrupt is 0 exactly while flag 0 and control bit 0 are both 1. Otherwise it is 1.
- R8: A match on alarm 1 with control bit 1 set drives the pulse output high for exactly PULSE_CYCLES consecutive cycles, starting on the cycle after the strobe.
- R9: While control bit 1 is 0, the pulse output is 0. Clearing that bit cancels a running pulse, and alarm 1 matches still set flag 1.
- R10: A new alarm 1 match during a pulse restarts the pulse, so the output stays high for a full PULSE_CYCLES from the cycle after the new strobe.
- R11: A set flag stays set through later strobes, whether or not they match, until a visit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (32.768 kHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Once-per-second strobe; time bytes are valid on this cycle |
| now_i | input | 32 | Current time {day, hour, min, sec} |
| alm0_i | input | 32 | Alarm 0 set {day, hour, min, sec}, bit 7 of each byte masks it |
| alm1_i | input | 32 | Alarm 1 set, same layout |
| ctrl_i | input | 8 | Control byte: bit 0 enables the level interrupt, bit 1 enables the pulse |
| visit_i | input | 1 | The bus address pointer lands on visit_addr_i this cycle |
| visit_addr_i | input | 8 | Register address being visited (bit 7 = write) |
| flags_o | output | 2 | Request flags, bit 0 alarm 0, bit 1 alarm 1 |
| irq_n_o | output | 1 | Active-low level interrupt for alarm 0 |
| irq_pulse_o | output | 1 | Active-high timed pulse for alarm 1 |

## Verification
The strobe that sets a flag and the pointer visit that clears it can fall in the same cycle. A second such pair is a fresh alarm 1 match arriving while a pulse is still running. The bench raises the strobe and a visit to 07h on the same cycle, then expects flag 0 to read 1 afterwards. It also fires a second matching strobe part way through a pulse and counts the high cycles that follow it, expecting a full PULSE_CYCLES with no low gap in between.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int N_ALARM   = 2;
    localparam int N_FIELD   = 4;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = N_ALARM * 0 + N_FIELD * BYTE_W;
    localparam int MASK_BIT  = 7;
    localparam int REG_BASE  = 7;   // first alarm register (seconds of alarm 0)
    localparam int EN_LEVEL  = 0;   // control bit enabling the level interrupt
    localparam int EN_PULSE  = 1;   // control bit enabling the timed pulse

    typedef logic [BYTE_W-1:0] reg_byte_t;

    typedef struct packed {
        reg_byte_t day;
        reg_byte_t hour;
        reg_byte_t min;
        reg_byte_t sec;
    } tod_word_t;

    // one field agrees when masked or when its value bits are equal
    function automatic logic field_hit(input reg_byte_t alm, input reg_byte_t now);
        return alm[MASK_BIT] | (alm[MASK_BIT-1:0] == now[MASK_BIT-1:0]);
    endfunction

endpackage

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
(
    input  logic [WORD_W-1:0] alm_i,
    input  logic [WORD_W-1:0] now_i,
    output logic              hit_o
);
    logic [N_FIELD-1:0] fld_ok;

    for (genvar f = 0; f < N_FIELD; f++) begin : g_field
        assign fld_ok[f] = field_hit(alm_i[f*BYTE_W +: BYTE_W], now_i[f*BYTE_W +: BYTE_W]);
    end

    assign hit_o = &fld_ok;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag
    import tod_alarm_pkg::*;
#(
    parameter int BASE = REG_BASE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_i,
    input  logic       visit_i,
    input  logic [7:0] visit_addr_i,
    output logic       flag_o
);
    localparam logic [6:0] WIN_LO = 7'(BASE);
    localparam logic [6:0] WIN_HI = 7'(BASE + N_FIELD - 1);

    logic [6:0] reg_idx;
    logic       clr;

    // read and write addresses differ only in bit 7
    assign reg_idx = visit_addr_i[6:0];
    assign clr     = visit_i && (reg_idx >= WIN_LO) && (reg_idx <= WIN_HI);

    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;   // a new alarm outranks a clear
        else if (clr)   flag_o <= 1'b0;
    end
endmodule

// File: rtl/tod_alarm_pulse.sv
module tod_alarm_pulse #(
    parameter int WIDTH = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

    logic          act_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            act_q  <= 1'b0;
            left_q <= '0;
        end else if (fire_i) begin
            act_q  <= 1'b1;
            left_q <= LOAD;
        end else if (act_q) begin
            if (left_q == '0) act_q  <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = act_q & en_i;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
#(
    parameter int PULSE_CYCLES = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [WORD_W-1:0]   now_i,
    input  logic [WORD_W-1:0]   alm0_i,
    input  logic [WORD_W-1:0]   alm1_i,
    input  logic [7:0]          ctrl_i,
    input  logic                visit_i,
    input  logic [7:0]          visit_addr_i,
    output logic [N_ALARM-1:0]  flags_o,
    output logic                irq_n_o,
    output logic                irq_pulse_o
);
    logic [WORD_W-1:0]  alm_set [N_ALARM];
    logic [N_ALARM-1:0] hit;

    assign alm_set[0] = alm0_i;
    assign alm_set[1] = alm1_i;

    for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
        tod_alarm_cmp u_cmp (
            .alm_i (alm_set[a]),
            .now_i (now_i),
            .hit_o (hit[a])
        );
        tod_alarm_flag #(.BASE(REG_BASE + a * N_FIELD)) u_flag (
            .clk          (clk),
            .rst          (rst),
            .set_i        (tick_i & hit[a]),
            .visit_i      (visit_i),
            .visit_addr_i (visit_addr_i),
            .flag_o       (flags_o[a])
        );
    end

    assign irq_n_o = ~(flags_o[0] & ctrl_i[EN_LEVEL]);

    tod_alarm_pulse #(.WIDTH(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .en_i    (ctrl_i[EN_PULSE]),
        .fire_i  (tick_i & hit[1]),
        .pulse_o (irq_pulse_o)
    );
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
    parameter int PULSE_CYCLES = 2048
) (
    input logic        clk,
    input logic        rst,
    input logic        tick_i,
    input logic [7:0]  ctrl_i,
    input logic        visit_i,
    input logic [7:0]  visit_addr_i,
    input logic [1:0]  flags_o,
    input logic        irq_n_o,
    input logic        irq_pulse_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 2);

    logic [CW-1:0] run_q;
    logic          in_win0;

    // consecutive high cycles of the pulse since the last strobe
    always_ff @(posedge clk) begin
        if (rst || !irq_pulse_o || tick_i) run_q <= '0;
        else if (run_q < CW'(PULSE_CYCLES + 1)) run_q <= run_q + 1'b1;
    end

    assign in_win0 = visit_i && (visit_addr_i[6:0] >= 7'h07) && (visit_addr_i[6:0] <= 7'h0A);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (flags_o == 2'b00) && irq_n_o && !irq_pulse_o);

    a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !$rose(flags_o[0]) && !$rose(flags_o[1]));

    a_r5_visit_clears0: assert property (@(posedge clk) disable iff (rst)
        in_win0 && !tick_i |=> !flags_o[0]);

    a_r7_level_needs_flag: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> flags_o[0] && ctrl_i[0]);

    a_r8_rise_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pulse_o) |-> $past(tick_i));

    a_r8_width_bound: assert property (@(posedge clk) disable iff (rst)
        irq_pulse_o |-> run_q < CW'(PULSE_CYCLES));

    a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i[1] |-> !irq_pulse_o);

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        flags_o[0] && !visit_i |=> flags_o[0]);
endmodule

bind tod_alarm tod_alarm_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .ctrl_i       (ctrl_i),
    .visit_i      (visit_i),
    .visit_addr_i (visit_addr_i),
    .flags_o      (flags_o),
    .irq_n_o      (irq_n_o),
    .irq_pulse_o  (irq_pulse_o)
);

// File: tb/tod_alarm_tb.sv
`timescale 1ns/1ps
module tod_alarm_tb;
    localparam int PW = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [31:0] now_i = '0;
    logic [31:0] alm0_i = '0;
    logic [31:0] alm1_i = '0;
    logic [7:0]  ctrl_i = '0;
    logic        visit_i = 1'b0;
    logic [7:0]  visit_addr_i = '0;
    logic [1:0]  flags_o;
    logic        irq_n_o;
    logic        irq_pulse_o;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] T_NOW = {8'h03, 8'h12, 8'h34, 8'h56};
    localparam logic [31:0] ALL_M = 32'h8080_8080;

    always #2.5 clk = ~clk;

    tod_alarm #(.PULSE_CYCLES(PW)) u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic visit(input logic [7:0] a);
        @(negedge clk) begin visit_i = 1'b1; visit_addr_i = a; end
        @(negedge clk) visit_i = 1'b0;
    endtask

    task automatic clear_all();
        visit(8'h07);
        visit(8'h0B);
    endtask

    function automatic int count_high_gapfree(input int dummy);
        return dummy;
    endfunction

    // counts consecutive high samples from now on
    task automatic measure_pulse(output int n);
        n = 0;
        while (irq_pulse_o && n < PW + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(flags_o == 2'b00, "R1 flags", flags_o, 0);
        check(irq_n_o == 1'b1, "R1 irq_n", irq_n_o, 1);
        check(irq_pulse_o == 1'b0, "R1 pulse", irq_pulse_o, 0);
        @(negedge clk) rst = 1'b0;
        check(flags_o == 2'b00, "R1 flags after release", flags_o, 0);
    endtask

    task automatic t_exact();
        now_i = T_NOW; alm0_i = T_NOW; alm1_i = {8'h04, 8'h12, 8'h34, 8'h56};
        strobe();
        check(flags_o[0] == 1'b1, "R2 full match sets flag0", flags_o[0], 1);
        check(flags_o[1] == 1'b0, "R2 day differs, flag1 clear", flags_o[1], 0);
        clear_all();
    endtask

    task automatic t_masks();
        now_i = T_NOW;
        alm0_i = ALL_M; alm1_i = {8'h84, 8'h80, 8'h35, 8'h56};
        strobe();
        check(flags_o[0] == 1'b1, "R3 all masked fires", flags_o[0], 1);
        check(flags_o[1] == 1'b0, "R3 minutes differ", flags_o[1], 0);
        alm1_i = {8'h84, 8'h91, 8'h34, 8'h56};
        strobe();
        check(flags_o[1] == 1'b1, "R3 hour/day masked fires", flags_o[1], 1);
        clear_all();
    endtask

    task automatic t_no_tick();
        now_i = T_NOW; alm0_i = T_NOW; alm1_i = ALL_M;
        repeat (5) @(negedge clk);
        check(flags_o == 2'b00, "R4 no strobe no flag", flags_o, 0);
    endtask

    task automatic t_windows();
        alm0_i = ALL_M; alm1_i = ALL_M; ctrl_i = 8'h00;
        strobe();
        visit(8'h06); visit(8'h0F); visit(8'h8F);
        check(flags_o == 2'b11, "R5 outside windows keeps flags", flags_o, 3);
        visit(8'h8A);
        check(flags_o == 2'b10, "R5 write to 8Ah clears flag0 only", flags_o, 2);
        visit(8'h0E);
        check(flags_o == 2'b00, "R5 read of 0Eh clears flag1", flags_o, 0);
        strobe();
        visit(8'h8B);
        check(flags_o == 2'b01, "R5 write to 8Bh clears flag1 only", flags_o, 1);
        clear_all();
    endtask

    task automatic t_race();
        alm0_i = ALL_M; alm1_i = 32'h0;
        @(negedge clk) begin tick_i = 1'b1; visit_i = 1'b1; visit_addr_i = 8'h07; end
        @(negedge clk) begin tick_i = 1'b0; visit_i = 1'b0; end
        check(flags_o[0] == 1'b1, "R6 set wins over clear", flags_o[0], 1);
        clear_all();
    endtask

    task automatic t_level();
        alm0_i = ALL_M; alm1_i = 32'h0; ctrl_i = 8'h00;
        strobe();
        check(irq_n_o == 1'b1, "R7 disabled stays high", irq_n_o, 1);
        @(negedge clk) ctrl_i = 8'h01;
        #1 check(irq_n_o == 1'b0, "R7 enabled with flag low", irq_n_o, 0);
        visit(8'h09);
        check(irq_n_o == 1'b1, "R7 released after clear", irq_n_o, 1);
        ctrl_i = 8'h00;
    endtask

    task automatic t_pulse();
        int n;
        alm0_i = 32'h0; alm1_i = ALL_M; ctrl_i = 8'h02;
        check(irq_pulse_o == 1'b0, "R8 idle low", irq_pulse_o, 0);
        strobe();
        measure_pulse(n);
        check(n == PW, "R8 pulse width", n, PW);
        check(irq_pulse_o == 1'b0, "R8 low after pulse", irq_pulse_o, 0);
        clear_all();
    endtask

    task automatic t_restart();
        int n;
        bit gap = 1'b0;
        alm1_i = ALL_M; ctrl_i = 8'h02;
        strobe();
        for (int i = 0; i < 300; i++) begin
            if (!irq_pulse_o) gap = 1'b1;
            @(negedge clk);
        end
        strobe();
        if (!irq_pulse_o) gap = 1'b1;
        measure_pulse(n);
        check(!gap, "R10 no gap before restart", gap, 0);
        check(n == PW, "R10 width after restart", n, PW);
        clear_all();
    endtask

    task automatic t_disable();
        alm1_i = ALL_M; ctrl_i = 8'h00;
        strobe();
        check(irq_pulse_o == 1'b0, "R9 disabled no pulse", irq_pulse_o, 0);
        check(flags_o[1] == 1'b1, "R9 flag1 still set", flags_o[1], 1);
        clear_all();
        ctrl_i = 8'h02;
        strobe();
        repeat (10) @(negedge clk);
        ctrl_i = 8'h00;
        #1 check(irq_pulse_o == 1'b0, "R9 cancel drops pulse", irq_pulse_o, 0);
        @(negedge clk) ctrl_i = 8'h02;
        repeat (3) @(negedge clk);
        check(irq_pulse_o == 1'b0, "R9 cancelled pulse stays off", irq_pulse_o, 0);
        ctrl_i = 8'h00;
        clear_all();
    endtask

    task automatic t_sticky();
        now_i = T_NOW; alm0_i = T_NOW;
        strobe();
        now_i = {8'h03, 8'h12, 8'h34, 8'h57};
        strobe(); strobe();
        check(flags_o[0] == 1'b1, "R11 flag persists", flags_o[0], 1);
        now_i = T_NOW;
        strobe();
        check(flags_o[0] == 1'b1, "R11 rematch keeps flag", flags_o[0], 1);
        clear_all();
        check(flags_o == 2'b00, "R11 cleared by visit", flags_o, 0);
    endtask

    initial begin
        t_reset();
        t_exact();
        t_masks();
        t_no_tick();
        t_windows();
        t_race();
        t_level();
        t_pulse();
        t_restart();
        t_disable();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule